// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every bus cycle seen by a processor core and raises a break request when a cycle meets a programmed condition. It has two independent channels. Each channel holds an address pattern and an address mask, plus qualifiers for direction (read or write), access kind (instruction fetch or data) and operand size. The second channel can also compare the data value on the bus against its own pattern and mask. Both the address condition and the data condition must hold in the same cycle for that channel to hit.

The block also watches cycles driven by another bus master after the core has handed the bus over. It checks these cycles only when a global enable allows it. Such cycles carry a narrower address, have no meaningful size and are always treated as data accesses. A hit sets a sticky per-channel flag, which software clears with a strobe. A hit also produces a single-cycle break request one clock later. Alongside the request the block reports the matched address and a tag. The tag tells the exception logic whether the channel asked for a break before or after the matched instruction executes.

Top module: `bus_break_unit`

## Requirements
- R1: On a core cycle the address compare width follows the cycle size (`bus_size` 00 byte, 01 word, 10 or 11 longword). A longword compares bits 31..2, a word bits 31..1 and a byte all bits.
- R2: A mask bit of 1 removes that address bit from the compare. In channel B's data mask, a 1 removes that data bit from the compare.
- R3: The direction qualifier is 2 bits: bit 0 accepts reads and bit 1 accepts writes. The kind qualifier is 2 bits: bit 0 accepts fetches and bit 1 accepts data accesses. A channel whose direction or kind qualifier is 00 never hits.
- R4: The size qualifier 00 accepts any size. 01, 10 and 11 accept only byte, word and longword core cycles respectively.
- R5: With `b_data_en` set, channel B hits only when its address condition and its data condition both hold in the same cycle.
- R6: When channel B's size qualifier is byte or word, data bits 31..16 of both pattern and mask take no part in the compare. A byte value is programmed by repeating it in bits 15..8 and 7..0.
- R7: A cycle with `bus_ext` set, which comes from another master while the bus is released, can hit only while `ext_enable` is 1. Otherwise it leaves both flags and the request unchanged.
- R8: On an external cycle the size qualifier is ignored and all address bits are compared. The cycle counts as a data access even if `bus_fetch` is set. Bus address bits 31..27 are taken as zero.
- R9: After reset both flags are 0. A hit sets its channel's flag one clock later. The flag stays set until its clear strobe is seen, and a hit in the same cycle as a clear leaves the flag set.
- R10: `break_req` is 0 after reset. It is 1 for exactly the clock after a cycle in which any channel hits, and `break_addr` then shows that cycle's bus address.
- R11: With the request, `break_after` shows the after-execution setting of channel A if channel A hit, and otherwise that of channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_size | input | 2 | 00 byte, 01 word, 1x longword |
| bus_write | input | 1 | 1 write, 0 read |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_ext | input | 1 | Cycle driven by another master while the bus is released |
| ext_enable | input | 1 | Allow external cycles to hit |
| a_addr | input | 32 | Channel A address pattern |
| a_mask | input | 32 | Channel A address mask, 1 = ignore |
| a_rw | input | 2 | Channel A direction qualifier |
| a_kind | input | 2 | Channel A fetch/data qualifier |
| a_size | input | 2 | Channel A size qualifier |
| a_after | input | 1 | Channel A breaks after execution |
| b_addr | input | 32 | Channel B address pattern |
| b_mask | input | 32 | Channel B address mask, 1 = ignore |
| b_rw | input | 2 | Channel B direction qualifier |
| b_kind | input | 2 | Channel B fetch/data qualifier |
| b_size | input | 2 | Channel B size qualifier |
| b_after | input | 1 | Channel B breaks after execution |
| b_data | input | 32 | Channel B data pattern |
| b_dmask | input | 32 | Channel B data mask, 1 = ignore |
| b_data_en | input | 1 | Channel B also compares data |
| clr_a | input | 1 | Clear strobe for channel A flag |
| clr_b | input | 1 | Clear strobe for channel B flag |
| flag_a | output | 1 | Sticky channel A hit flag |
| flag_b | output | 1 | Sticky channel B hit flag |
| break_req | output | 1 | One-clock break request |
| break_after | output | 1 | Tag for the request: 1 = after execution |
| break_addr | output | 32 | Address of the cycle that hit |

## Verification
The assertions check the relation between each channel's hit and the registered outputs on every cycle. A hit always sets its flag and always produces a request one clock later. A flag stays set until a clear arrives, and the request stays low when there was no hit. They also check that invalid cycles, disabled channels and gated external cycles never hit. Whether a hit is correct in the first place cannot be seen that way, so only the bench's scenarios show it. Those scenarios cover the size-dependent address width, masking, the data compare and its upper-half rule, external address truncation, and the tag priority between channels.

// File: rtl/brk_pkg.sv
package brk_pkg;
    // bus cycle size codes
    localparam logic [1:0] BS_BYTE = 2'b00;
    localparam logic [1:0] BS_WORD = 2'b01;
    localparam logic [1:0] BS_LONG = 2'b10;

    // channel size qualifier codes
    localparam logic [1:0] QS_ANY  = 2'b00;
    localparam logic [1:0] QS_BYTE = 2'b01;
    localparam logic [1:0] QS_WORD = 2'b10;
    localparam logic [1:0] QS_LONG = 2'b11;

    localparam int NCH = 2;
endpackage

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
    import brk_pkg::*;
#(
    parameter int AW     = 32,
    parameter int EXT_AW = 27
) (
    input  logic [AW-1:0] pat,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          ext,
    output logic          hit
);
    logic [AW-1:0] eff;
    logic [AW-1:0] care;

    always_comb begin
        eff  = addr;
        care = ~mask;
        if (ext) begin
            // the other master drives only the low address lines
            eff[AW-1:EXT_AW] = '0;
        end else begin
            unique case (size)
                BS_BYTE: ;
                BS_WORD: care[0] = 1'b0;
                default: care[1:0] = 2'b00;
            endcase
        end
        hit = ((eff ^ pat) & care) == '0;
    end
endmodule

// File: rtl/brk_qual.sv
module brk_qual
    import brk_pkg::*;
(
    input  logic [1:0] q_rw,
    input  logic [1:0] q_kind,
    input  logic [1:0] q_size,
    input  logic       bus_write,
    input  logic       bus_fetch,
    input  logic [1:0] bus_size,
    input  logic       ext,
    output logic       ok
);
    logic rw_ok;
    logic kind_ok;
    logic size_ok;

    always_comb begin
        rw_ok   = bus_write ? q_rw[1] : q_rw[0];
        // external cycles are always data accesses
        kind_ok = (bus_fetch && !ext) ? q_kind[0] : q_kind[1];
        if (ext || q_size == QS_ANY) begin
            size_ok = 1'b1;
        end else begin
            unique case (q_size)
                QS_BYTE: size_ok = (bus_size == BS_BYTE);
                QS_WORD: size_ok = (bus_size == BS_WORD);
                default: size_ok = bus_size[1];
            endcase
        end
        ok = rw_ok && kind_ok && size_ok;
    end
endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
    import brk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] pat,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] data,
    input  logic [1:0]    q_size,
    output logic          hit
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] care;

    always_comb begin
        care = ~mask;
        if (q_size == QS_BYTE || q_size == QS_WORD) begin
            care[DW-1:HALF] = '0;
        end
        hit = !en || (((data ^ pat) & care) == '0);
    end
endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int EXT_AW = 27
) (
    input  logic          live,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    bus_size,
    input  logic          bus_write,
    input  logic          bus_fetch,
    input  logic          bus_ext,
    input  logic [AW-1:0] c_addr,
    input  logic [AW-1:0] c_mask,
    input  logic [1:0]    c_rw,
    input  logic [1:0]    c_kind,
    input  logic [1:0]    c_size,
    input  logic          c_den,
    input  logic [DW-1:0] c_data,
    input  logic [DW-1:0] c_dmask,
    output logic          hit
);
    logic addr_hit;
    logic qual_ok;
    logic data_hit;

    brk_addr_cmp #(.AW(AW), .EXT_AW(EXT_AW)) u_addr (
        .pat  (c_addr),
        .mask (c_mask),
        .addr (bus_addr),
        .size (bus_size),
        .ext  (bus_ext),
        .hit  (addr_hit)
    );

    brk_qual u_qual (
        .q_rw      (c_rw),
        .q_kind    (c_kind),
        .q_size    (c_size),
        .bus_write (bus_write),
        .bus_fetch (bus_fetch),
        .bus_size  (bus_size),
        .ext       (bus_ext),
        .ok        (qual_ok)
    );

    brk_data_cmp #(.DW(DW)) u_data (
        .en     (c_den),
        .pat    (c_data),
        .mask   (c_dmask),
        .data   (bus_data),
        .q_size (c_size),
        .hit    (data_hit)
    );

    assign hit = live && qual_ok && addr_hit && data_hit;
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import brk_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int EXT_AW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    bus_size,
    input  logic          bus_write,
    input  logic          bus_fetch,
    input  logic          bus_ext,
    input  logic          ext_enable,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] a_mask,
    input  logic [1:0]    a_rw,
    input  logic [1:0]    a_kind,
    input  logic [1:0]    a_size,
    input  logic          a_after,
    input  logic [AW-1:0] b_addr,
    input  logic [AW-1:0] b_mask,
    input  logic [1:0]    b_rw,
    input  logic [1:0]    b_kind,
    input  logic [1:0]    b_size,
    input  logic          b_after,
    input  logic [DW-1:0] b_data,
    input  logic [DW-1:0] b_dmask,
    input  logic          b_data_en,
    input  logic          clr_a,
    input  logic          clr_b,
    output logic          flag_a,
    output logic          flag_b,
    output logic          break_req,
    output logic          break_after,
    output logic [AW-1:0] break_addr
);
    typedef struct packed {
        logic [NCH-1:0] flag;
        logic           req;
        logic           after;
        logic [AW-1:0]  baddr;
    } state_t;

    state_t state_d, state_q;

    logic [AW-1:0]  ch_addr  [NCH];
    logic [AW-1:0]  ch_mask  [NCH];
    logic [1:0]     ch_rw    [NCH];
    logic [1:0]     ch_kind  [NCH];
    logic [1:0]     ch_size  [NCH];
    logic           ch_den   [NCH];
    logic [DW-1:0]  ch_data  [NCH];
    logic [DW-1:0]  ch_dmask [NCH];
    logic [NCH-1:0] ch_after;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] hit;
    logic           live;

    // channel A has no data compare: tie it open
    assign ch_addr[0]  = a_addr;
    assign ch_mask[0]  = a_mask;
    assign ch_rw[0]    = a_rw;
    assign ch_kind[0]  = a_kind;
    assign ch_size[0]  = a_size;
    assign ch_den[0]   = 1'b0;
    assign ch_data[0]  = '0;
    assign ch_dmask[0] = '1;
    assign ch_addr[1]  = b_addr;
    assign ch_mask[1]  = b_mask;
    assign ch_rw[1]    = b_rw;
    assign ch_kind[1]  = b_kind;
    assign ch_size[1]  = b_size;
    assign ch_den[1]   = b_data_en;
    assign ch_data[1]  = b_data;
    assign ch_dmask[1] = b_dmask;
    assign ch_after    = {b_after, a_after};
    assign clr         = {clr_b, clr_a};

    assign live = bus_valid && (!bus_ext || ext_enable);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        brk_channel #(.AW(AW), .DW(DW), .EXT_AW(EXT_AW)) u_ch (
            .live      (live),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_size  (bus_size),
            .bus_write (bus_write),
            .bus_fetch (bus_fetch),
            .bus_ext   (bus_ext),
            .c_addr    (ch_addr[c]),
            .c_mask    (ch_mask[c]),
            .c_rw      (ch_rw[c]),
            .c_kind    (ch_kind[c]),
            .c_size    (ch_size[c]),
            .c_den     (ch_den[c]),
            .c_data    (ch_data[c]),
            .c_dmask   (ch_dmask[c]),
            .hit       (hit[c])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.req = |hit;
        for (int c = 0; c < NCH; c++) begin
            if (clr[c]) state_d.flag[c] = 1'b0;
            if (hit[c]) state_d.flag[c] = 1'b1;
        end
        if (|hit) begin
            // lowest channel wins the tag
            state_d.after = hit[0] ? ch_after[0] : ch_after[1];
            state_d.baddr = bus_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flag_a      = state_q.flag[0];
    assign flag_b      = state_q.flag[1];
    assign break_req   = state_q.req;
    assign break_after = state_q.after;
    assign break_addr  = state_q.baddr;
endmodule

// File: rtl/brk_checker.sv
module brk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hit,
    input logic       flag_a,
    input logic       flag_b,
    input logic       clr_a,
    input logic       clr_b,
    input logic       break_req,
    input logic       bus_valid,
    input logic       bus_ext,
    input logic       ext_enable,
    input logic [1:0] a_rw,
    input logic [1:0] a_kind,
    input logic [1:0] b_rw,
    input logic [1:0] b_kind
);
    // R9: a hit sets its flag
    a_r9_set_a: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> flag_a);
    a_r9_set_b: assert property (@(posedge clk) disable iff (!rst_n) hit[1] |=> flag_b);
    // R9: sticky without clear, cleared with clear and no hit
    a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n) flag_a && !clr_a |=> flag_a);
    a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n) flag_b && !clr_b |=> flag_b);
    a_r9_clr_a: assert property (@(posedge clk) disable iff (!rst_n) clr_a && !hit[0] |=> !flag_a);
    a_r9_clr_b: assert property (@(posedge clk) disable iff (!rst_n) clr_b && !hit[1] |=> !flag_b);
    // R10: request follows hits by one clock
    a_r10_req_on: assert property (@(posedge clk) disable iff (!rst_n) (|hit) |=> break_req);
    a_r10_req_off: assert property (@(posedge clk) disable iff (!rst_n) !(|hit) |=> !break_req);
    // R3: disabled channel never hits
    a_r3_off_a: assert property (@(posedge clk) disable iff (!rst_n) (a_rw == 2'b00 || a_kind == 2'b00) |-> !hit[0]);
    a_r3_off_b: assert property (@(posedge clk) disable iff (!rst_n) (b_rw == 2'b00 || b_kind == 2'b00) |-> !hit[1]);
    // R7: gated external cycles and empty cycles never hit
    a_r7_ext_gate: assert property (@(posedge clk) disable iff (!rst_n) (bus_ext && !ext_enable) |-> hit == 2'b00);
    a_r10_no_cycle: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |-> hit == 2'b00);
endmodule

bind bus_break_unit brk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .flag_a     (flag_a),
    .flag_b     (flag_b),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .break_req  (break_req),
    .bus_valid  (bus_valid),
    .bus_ext    (bus_ext),
    .ext_enable (ext_enable),
    .a_rw       (a_rw),
    .a_kind     (a_kind),
    .b_rw       (b_rw),
    .b_kind     (b_kind)
);

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_ext = 1'b0;
    logic        ext_enable = 1'b0;
    logic [1:0]  clr = '0;

    logic [31:0] c_addr [2];
    logic [31:0] c_mask [2];
    logic [1:0]  c_rw   [2];
    logic [1:0]  c_kind [2];
    logic [1:0]  c_sz   [2];
    logic        c_after [2];
    logic [31:0] c_data = '0;
    logic [31:0] c_dmask = '0;
    logic        c_den = 1'b0;

    logic        flag_a, flag_b, break_req, break_after;
    logic [31:0] break_addr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [1:0]  exp_flag = '0;
    logic        exp_req = 1'b0;
    logic        exp_after = 1'b0;
    logic [31:0] exp_baddr = '0;

    always #2.5 clk = ~clk;

    bus_break_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_size(bus_size), .bus_write(bus_write),
        .bus_fetch(bus_fetch), .bus_ext(bus_ext), .ext_enable(ext_enable),
        .a_addr(c_addr[0]), .a_mask(c_mask[0]), .a_rw(c_rw[0]), .a_kind(c_kind[0]),
        .a_size(c_sz[0]), .a_after(c_after[0]),
        .b_addr(c_addr[1]), .b_mask(c_mask[1]), .b_rw(c_rw[1]), .b_kind(c_kind[1]),
        .b_size(c_sz[1]), .b_after(c_after[1]), .b_data(c_data), .b_dmask(c_dmask),
        .b_data_en(c_den), .clr_a(clr[0]), .clr_b(clr[1]),
        .flag_a(flag_a), .flag_b(flag_b), .break_req(break_req),
        .break_after(break_after), .break_addr(break_addr)
    );

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference from the requirements
    function automatic logic m_hit(input int ch);
        logic [31:0] a;
        logic [31:0] care;
        logic [31:0] keep;
        logic ok;
        if (!bus_valid) return 1'b0;
        if (bus_ext && !ext_enable) return 1'b0;                       // R7
        ok = bus_write ? c_rw[ch][1] : c_rw[ch][0];                    // R3
        ok = ok && (((bus_fetch && !bus_ext) ? c_kind[ch][0] : c_kind[ch][1])); // R3, R8
        if (!bus_ext && c_sz[ch] != 2'b00) begin                       // R4
            if (c_sz[ch] == 2'b11) ok = ok && bus_size[1];
            else ok = ok && (bus_size == c_sz[ch] - 2'b01);
        end
        a = bus_ext ? (bus_addr & 32'h07FF_FFFF) : bus_addr;           // R8
        care = ~c_mask[ch];                                            // R2
        if (!bus_ext) begin                                            // R1
            if (bus_size == 2'b01) care[0] = 1'b0;
            else if (bus_size[1]) care[1:0] = 2'b00;
        end
        ok = ok && (((a ^ c_addr[ch]) & care) == 32'h0);
        if (ch == 1 && c_den) begin                                    // R5, R6
            keep = (c_sz[1] == 2'b01 || c_sz[1] == 2'b10) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
            ok = ok && (((bus_data ^ c_data) & ~c_dmask & keep) == 32'h0);
        end
        return ok;
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic wr, input logic fe, input logic ex,
                        input logic [1:0] cl, input int want, input string tag);
        logic h0, h1;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d; bus_size = sz;
        bus_write = wr; bus_fetch = fe; bus_ext = ex; clr = cl;
        h0 = m_hit(0);
        h1 = m_hit(1);
        if (cl[0]) exp_flag[0] = 1'b0;
        if (cl[1]) exp_flag[1] = 1'b0;
        if (h0) exp_flag[0] = 1'b1;
        if (h1) exp_flag[1] = 1'b1;
        exp_req = h0 | h1;
        if (exp_req) begin
            exp_after = h0 ? c_after[0] : c_after[1];
            exp_baddr = a;
        end
        @(posedge clk);
        #1;
        chk({flag_b, flag_a} == exp_flag, {tag, " R9 flags"}, {30'b0, flag_b, flag_a}, {30'b0, exp_flag});
        chk(break_req == exp_req, {tag, " R10 request"}, {31'b0, break_req}, {31'b0, exp_req});
        if (exp_req) begin
            chk(break_after == exp_after, {tag, " R11 tag"}, {31'b0, break_after}, {31'b0, exp_after});
            chk(break_addr == exp_baddr, {tag, " R10 addr"}, break_addr, exp_baddr);
        end
        if (want >= 0)
            chk(break_req == want[0], tag, {31'b0, break_req}, want);
    endtask

    task automatic cfg(input int ch, input logic [31:0] a, input logic [31:0] m,
                       input logic [1:0] rw, input logic [1:0] kd, input logic [1:0] sz, input logic af);
        c_addr[ch] = a; c_mask[ch] = m; c_rw[ch] = rw; c_kind[ch] = kd; c_sz[ch] = sz; c_after[ch] = af;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cfg(0, 32'h0, 32'h0, 2'b00, 2'b00, 2'b00, 1'b0);
        cfg(1, 32'h0, 32'h0, 2'b00, 2'b00, 2'b00, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk({flag_b, flag_a, break_req} == 3'b000, "R9 R10 reset", {29'b0, flag_b, flag_a, break_req}, 32'h0);
        rst_n = 1'b1;

        // R3: disabled after reset even on a matching address
        step(1, 32'h0, 32'h0, 2'b10, 0, 0, 0, 2'b00, 0, "R3 disabled");

        // R1: longword/word/byte compare widths
        cfg(0, 32'h0000_1000, 32'h0, 2'b11, 2'b11, 2'b00, 1'b1);
        step(1, 32'h0000_1003, 32'h0, 2'b10, 0, 0, 0, 2'b11, 1, "R1 long ignores 1:0");
        step(1, 32'h0000_1003, 32'h0, 2'b01, 0, 0, 0, 2'b11, 0, "R1 word sees bit1");
        step(1, 32'h0000_1001, 32'h0, 2'b01, 0, 0, 0, 2'b11, 1, "R1 word ignores bit0");
        step(1, 32'h0000_1001, 32'h0, 2'b00, 0, 0, 0, 2'b11, 0, "R1 byte sees bit0");
        // R2: mask
        cfg(0, 32'h0000_1000, 32'h0000_00F0, 2'b11, 2'b11, 2'b00, 1'b0);
        step(1, 32'h0000_10A0, 32'h0, 2'b00, 0, 0, 0, 2'b11, 1, "R2 masked bits");
        step(1, 32'h0000_11A0, 32'h0, 2'b00, 0, 0, 0, 2'b11, 0, "R2 unmasked bit");
        // R3: read only
        cfg(0, 32'h0000_1000, 32'h0, 2'b01, 2'b11, 2'b00, 1'b0);
        step(1, 32'h0000_1000, 32'h0, 2'b10, 1, 0, 0, 2'b11, 0, "R3 write refused");
        step(1, 32'h0000_1000, 32'h0, 2'b10, 0, 0, 0, 2'b11, 1, "R3 read accepted");
        cfg(0, 32'h0000_1000, 32'h0, 2'b11, 2'b10, 2'b00, 1'b0);
        step(1, 32'h0000_1000, 32'h0, 2'b10, 0, 1, 0, 2'b11, 0, "R3 fetch refused");
        // R4: size qualifier
        cfg(0, 32'h0000_1000, 32'h0, 2'b11, 2'b11, 2'b10, 1'b0);
        step(1, 32'h0000_1000, 32'h0, 2'b00, 0, 0, 0, 2'b11, 0, "R4 byte vs word qual");
        step(1, 32'h0000_1000, 32'h0, 2'b01, 0, 0, 0, 2'b11, 1, "R4 word vs word qual");
        cfg(0, 32'h0, 32'h0, 2'b00, 2'b00, 2'b00, 1'b0);

        // R5: data condition on B
        cfg(1, 32'h0000_2000, 32'h0, 2'b11, 2'b11, 2'b11, 1'b0);
        c_den = 1'b1; c_data = 32'h1234_5678; c_dmask = 32'h0;
        step(1, 32'h0000_2000, 32'h1234_5679, 2'b10, 1, 0, 0, 2'b11, 0, "R5 data mismatch");
        step(1, 32'h0000_2000, 32'h1234_5678, 2'b10, 1, 0, 0, 2'b11, 1, "R5 both match");
        step(1, 32'h0000_2004, 32'h1234_5678, 2'b10, 1, 0, 0, 2'b11, 0, "R5 addr mismatch");
        c_dmask = 32'h0000_000F;
        step(1, 32'h0000_2000, 32'h1234_567F, 2'b10, 1, 0, 0, 2'b11, 1, "R2 data mask");
        // R6: byte data in both low bytes, upper half ignored
        cfg(1, 32'h0000_2001, 32'h0, 2'b11, 2'b11, 2'b01, 1'b0);
        c_data = 32'h0000_5A5A; c_dmask = 32'h0;
        step(1, 32'h0000_2001, 32'hFFFF_5A5A, 2'b00, 1, 0, 0, 2'b11, 1, "R6 upper half ignored");
        step(1, 32'h0000_2001, 32'hFFFF_5A5B, 2'b00, 1, 0, 0, 2'b11, 0, "R6 low byte differs");
        c_den = 1'b0;

        // R7 / R8: external cycles
        cfg(1, 32'h0000_1000, 32'h0, 2'b11, 2'b10, 2'b11, 1'b0);
        ext_enable = 1'b0;
        step(1, 32'h0000_1000, 32'h0, 2'b00, 0, 0, 1, 2'b11, 0, "R7 gated ext");
        ext_enable = 1'b1;
        step(1, 32'h0000_1000, 32'h0, 2'b00, 0, 0, 1, 2'b11, 1, "R8 ext size ignored");
        step(1, 32'hF800_1000, 32'h0, 2'b10, 0, 1, 1, 2'b11, 1, "R8 top bits zero, fetch as data");
        step(1, 32'h0000_1001, 32'h0, 2'b10, 0, 0, 1, 2'b11, 0, "R8 full compare");
        cfg(1, 32'h1000_1000, 32'h0, 2'b11, 2'b10, 2'b00, 1'b0);
        step(1, 32'h1000_1000, 32'h0, 2'b10, 0, 0, 1, 2'b11, 0, "R8 high pattern bit");
        ext_enable = 1'b0;

        // R9 sticky, R10 pulse, R11 priority
        cfg(0, 32'h0000_3000, 32'h0, 2'b11, 2'b11, 2'b00, 1'b1);
        cfg(1, 32'h0000_3000, 32'h0, 2'b11, 2'b11, 2'b00, 1'b0);
        step(1, 32'h0000_3000, 32'h0, 2'b10, 0, 1, 0, 2'b11, 1, "R11 both hit");
        step(0, 32'h0, 32'h0, 2'b10, 0, 0, 0, 2'b00, 0, "R10 single pulse");
        chk(flag_a && flag_b, "R9 sticky", {30'b0, flag_b, flag_a}, 32'h3);
        step(0, 32'h0, 32'h0, 2'b10, 0, 0, 0, 2'b01, 0, "R9 clear A");
        chk(!flag_a && flag_b, "R9 clear only A", {30'b0, flag_b, flag_a}, 32'h2);
        c_rw[0] = 2'b00; c_after[1] = 1'b1;
        step(1, 32'h0000_3000, 32'h0, 2'b10, 0, 1, 0, 2'b10, 1, "R11 B only");
        chk(break_after == 1'b1, "R11 tag from B", {31'b0, break_after}, 32'h1);

        // random phase
        for (int ph = 0; ph < 60; ph++) begin
            for (int ch = 0; ch < 2; ch++)
                cfg(ch, $urandom, $urandom & $urandom & $urandom, 2'($urandom), 2'($urandom),
                    2'($urandom), 1'($urandom));
            c_den = 1'($urandom);
            c_data = $urandom;
            if ($urandom % 3 == 0) c_data[15:8] = c_data[7:0];
            c_dmask = $urandom & $urandom & $urandom;
            ext_enable = 1'($urandom);
            for (int k = 0; k < 60; k++) begin
                logic [31:0] a;
                logic [31:0] d;
                int pick;
                pick = $urandom % 2;
                a = ($urandom % 4 == 0) ? $urandom : (c_addr[pick] ^ ($urandom & 32'h7));
                if ($urandom % 4 == 0) a = a ^ ({$urandom} & 32'hF800_0000);
                d = ($urandom % 3 == 0) ? $urandom : (c_data ^ ($urandom & $urandom & 32'hFFFF_0003));
                step(1'($urandom % 8 != 0), a, d, 2'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom % 4 == 0), ($urandom % 8 == 0) ? 2'($urandom) : 2'b00, -1,
                     "R1 R4 R5 random");
            end
        end
        finish_run();
    end
endmodule